// File: doc/BRIEF.md
# Shared Packet Buffer with Rebindable Access Ports

This block holds one packet buffer memory shared by eight pipes. Each pipe gets its own region of whole 64-byte blocks, set by a start block and a size field. CPU software reaches the buffer through three access ports. Each port is bound to one pipe at a time and can be rebound at any time. A port keeps a byte pointer that walks forward through the bound pipe's region on every accepted access. Accesses that would leave the region are refused and set a sticky error.

Each pipe's buffer belongs either to the CPU or to the serial engine. A CPU "done" strobe on a port passes the bound pipe to the serial engine. A serial-engine "done" strobe passes the pipe back to the CPU and rewinds every port bound to it. The serial engine has its own address and data path, which works only on pipes it owns. When two ports are bound to the same pipe, a conflict flag is raised and only the lowest-numbered of those ports is served.

Top module: `pipe_buf_ports`

## Requirements
- R1: After reset, every pipe belongs to the CPU, port p is bound to pipe p with its pointer at byte 0, and every region has start 0 and size 0. As a result, `port_rdy` is all ones and `conflict` and `port_err` are zero.
- R2: A pipe configured with start block s and size field z covers byte addresses s*64 through (s+z+1)*64-1 inclusive. For example, size 0 covers exactly 64 bytes.
- R3: Binding a port to a pipe moves that port's pointer to the first byte of the pipe's region and clears the port's error, both effective on the next cycle. A CPU access presented on that same port in the binding cycle is dropped (`cpu_ack` is 0).
- R4: An accepted CPU access (`cpu_ack` 1 in the same cycle) uses the port's pointer as its address, then moves the pointer forward by one. Read data appears on `cpu_rdata` one cycle after the acknowledge.
- R5: A CPU access on a ready port whose pointer lies past the region's last byte is refused. It sets that port's `port_err` bit, which stays at 1 until that port is bound again.
- R6: `port_rdy[p]` is 1 exactly when the CPU owns the pipe bound to port p and no lower-numbered port is bound to the same pipe. `conflict` is 1 whenever any two ports share a pipe. A CPU access on a port that is not ready is not acknowledged.
- R7: A `cpu_done` strobe on a ready port hands the bound pipe to the serial engine from the next cycle, so the port's ready flag drops.
- R8: A `sie_done` strobe for a pipe owned by the serial engine returns the pipe to the CPU and rewinds every port bound to it to the region's first byte.
- R9: A serial-engine access is acknowledged in the same cycle only when the serial engine owns `sie_pipe` and the absolute byte address `sie_addr` lies inside that pipe's region. Read data appears on `sie_rdata` one cycle later.
- R10: Bit q of `pipe_cpu_own` is 1 when the CPU owns pipe q and 0 when the serial engine owns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write region configuration |
| cfg_pipe | input | 3 | Pipe whose region is written |
| cfg_start | input | 5 | First block of the region |
| cfg_size | input | 5 | Region size field (blocks minus one) |
| sel_we | input | 1 | Bind a port to a pipe |
| sel_port | input | 2 | Port being bound |
| sel_pipe | input | 3 | Pipe it is bound to |
| cpu_req | input | 1 | CPU access request |
| cpu_port | input | 2 | Port used for the access |
| cpu_wr | input | 1 | 1 write, 0 read |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_ack | output | 1 | Access accepted this cycle |
| cpu_rdata | output | 8 | CPU read byte, one cycle after acknowledge |
| cpu_done | input | 1 | CPU hands the bound pipe to the serial engine |
| cpu_done_port | input | 2 | Port whose pipe is handed over |
| sie_req | input | 1 | Serial-engine access request |
| sie_wr | input | 1 | 1 write, 0 read |
| sie_pipe | input | 3 | Pipe the serial engine addresses |
| sie_addr | input | 11 | Absolute byte address |
| sie_wdata | input | 8 | Serial-engine write byte |
| sie_ack | output | 1 | Serial-engine access accepted |
| sie_rdata | output | 8 | Serial-engine read byte, one cycle later |
| sie_done | input | 1 | Serial engine returns a pipe to the CPU |
| sie_done_pipe | input | 3 | Pipe being returned |
| port_rdy | output | 3 | Per-port CPU access right |
| port_err | output | 3 | Per-port sticky region-overflow error |
| conflict | output | 1 | Two ports share a pipe |
| pipe_cpu_own | output | 8 | Per-pipe owner: 1 CPU, 0 serial engine |

## Verification
Rebinding a port and presenting a CPU access on that same port can happen in the same cycle. Both act on that port's pointer. The bench provokes this by advancing port 0 with one read, then binding it again while a read is requested on it. The rebind must win: the acknowledge is judged low in that cycle, and the next read on the port must return the region's first byte, not the second.

// File: rtl/pipe_buf_ports.sv
module pipe_buf_ports #(
  parameter int NPIPE = 8,
  parameter int NPORT = 3,
  parameter int NBLK = 32,
  parameter int BLK_BYTES = 64,
  parameter int DW = 8,
  localparam int PIW = $clog2(NPIPE),
  localparam int POW = $clog2(NPORT),
  localparam int BLKW = $clog2(NBLK),
  localparam int DEPTH = NBLK * BLK_BYTES,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [PIW-1:0]  cfg_pipe,
  input  logic [BLKW-1:0] cfg_start,
  input  logic [BLKW-1:0] cfg_size,
  input  logic            sel_we,
  input  logic [POW-1:0]  sel_port,
  input  logic [PIW-1:0]  sel_pipe,
  input  logic            cpu_req,
  input  logic [POW-1:0]  cpu_port,
  input  logic            cpu_wr,
  input  logic [DW-1:0]   cpu_wdata,
  output logic            cpu_ack,
  output logic [DW-1:0]   cpu_rdata,
  input  logic            cpu_done,
  input  logic [POW-1:0]  cpu_done_port,
  input  logic            sie_req,
  input  logic            sie_wr,
  input  logic [PIW-1:0]  sie_pipe,
  input  logic [AW-1:0]   sie_addr,
  input  logic [DW-1:0]   sie_wdata,
  output logic            sie_ack,
  output logic [DW-1:0]   sie_rdata,
  input  logic            sie_done,
  input  logic [PIW-1:0]  sie_done_pipe,
  output logic [NPORT-1:0] port_rdy,
  output logic [NPORT-1:0] port_err,
  output logic            conflict,
  output logic [NPIPE-1:0] pipe_cpu_own
);
  localparam int PW  = AW + 1;
  localparam int BSH = $clog2(BLK_BYTES);

  logic [BLKW-1:0] rstart [NPIPE];
  logic [BLKW-1:0] rsize  [NPIPE];
  logic [PW-1:0]   pbase  [NPIPE];
  logic [PW-1:0]   plast  [NPIPE];
  logic [PIW-1:0]  sel    [NPORT];
  logic [PW-1:0]   ptr    [NPORT];
  logic [NPORT-1:0] gnt;
  logic [NPIPE-1:0] own;
  logic [DW-1:0]   mem [DEPTH];

  always_comb
    for (int q = 0; q < NPIPE; q++) begin
      pbase[q] = PW'(rstart[q]) << BSH;
      plast[q] = ((PW'(rstart[q]) + PW'(rsize[q]) + PW'(1)) << BSH) - PW'(1);
    end

  always_comb begin
    conflict = 1'b0;
    for (int p = 0; p < NPORT; p++) begin
      gnt[p] = 1'b1;
      for (int k = 0; k < p; k++)
        if (sel[k] == sel[p]) begin
          gnt[p]   = 1'b0;
          conflict = 1'b1;
        end
      port_rdy[p] = gnt[p] & own[sel[p]];
    end
  end

  assign pipe_cpu_own = own;

  wire            port_ok = 32'(cpu_port) < NPORT;
  wire            done_ok = 32'(cpu_done_port) < NPORT;
  wire [PIW-1:0]  cur_sel = sel[cpu_port];
  wire [PW-1:0]   cur_ptr = ptr[cpu_port];
  wire [PIW-1:0]  dn_sel  = sel[cpu_done_port];
  wire            sel_hit = sel_we && sel_port == cpu_port;
  wire            cpu_try = cpu_req && port_ok && port_rdy[cpu_port] && !sel_hit;
  wire            in_rng  = cur_ptr <= plast[cur_sel] && cur_ptr < PW'(DEPTH);
  wire            dn_ok   = cpu_done && done_ok && port_rdy[cpu_done_port];
  wire            ret_ok  = sie_done && !own[sie_done_pipe];
  wire [PW-1:0]   sie_a   = {1'b0, sie_addr};

  assign cpu_ack = cpu_try && in_rng;
  assign sie_ack = sie_req && !own[sie_pipe] &&
                   sie_a >= pbase[sie_pipe] && sie_a <= plast[sie_pipe];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own <= '1;
      port_err <= '0;
      for (int q = 0; q < NPIPE; q++) begin
        rstart[q] <= '0;
        rsize[q]  <= '0;
      end
      for (int p = 0; p < NPORT; p++) begin
        sel[p] <= PIW'(p);
        ptr[p] <= '0;
      end
    end else begin
      if (cfg_we) begin
        rstart[cfg_pipe] <= cfg_start;
        rsize[cfg_pipe]  <= cfg_size;
      end
      if (dn_ok) own[dn_sel] <= 1'b0;
      if (ret_ok) own[sie_done_pipe] <= 1'b1;
      for (int p = 0; p < NPORT; p++) begin
        if (sel_we && 32'(sel_port) == p) begin
          sel[p] <= sel_pipe;
          ptr[p] <= pbase[sel_pipe];
          port_err[p] <= 1'b0;
        end else begin
          if (ret_ok && sel[p] == sie_done_pipe)
            ptr[p] <= pbase[sel[p]];
          else if (cpu_ack && 32'(cpu_port) == p)
            ptr[p] <= ptr[p] + PW'(1);
          if (cpu_try && !in_rng && 32'(cpu_port) == p)
            port_err[p] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (cpu_ack) begin
      if (cpu_wr) mem[cur_ptr[AW-1:0]] <= cpu_wdata;
      else        cpu_rdata <= mem[cur_ptr[AW-1:0]];
    end
    if (sie_ack) begin
      if (sie_wr) mem[sie_addr] <= sie_wdata;
      else        sie_rdata <= mem[sie_addr];
    end
  end

  p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> ptr[$past(cpu_port)] == $past(cur_ptr) + PW'(1));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_try && !in_rng |=> port_err[$past(cpu_port)]);

  p_conflict_r6: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> !(&port_rdy));

  p_handoff_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dn_ok && !ret_ok |=> !pipe_cpu_own[$past(dn_sel)]);

  p_return_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ret_ok |=> pipe_cpu_own[$past(sie_done_pipe)]);

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack && sie_ack |-> sie_pipe != cur_sel);

  for (genvar g = 0; g < NPORT; g++) begin : g_err
    p_err_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      port_err[g] && !(sel_we && 32'(sel_port) == g) |=> port_err[g]);
  end
endmodule

// File: tb/pipe_buf_ports_test.sv
`timescale 1ns/1ps
module pipe_buf_ports_test;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [2:0] cfg_pipe = 0; logic [4:0] cfg_start = 0, cfg_size = 0;
  logic sel_we = 0; logic [1:0] sel_port = 0; logic [2:0] sel_pipe = 0;
  logic cpu_req = 0; logic [1:0] cpu_port = 0; logic cpu_wr = 0; logic [7:0] cpu_wdata = 0;
  logic cpu_ack; logic [7:0] cpu_rdata;
  logic cpu_done = 0; logic [1:0] cpu_done_port = 0;
  logic sie_req = 0, sie_wr = 0; logic [2:0] sie_pipe = 0; logic [10:0] sie_addr = 0;
  logic [7:0] sie_wdata = 0; logic sie_ack; logic [7:0] sie_rdata;
  logic sie_done = 0; logic [2:0] sie_done_pipe = 0;
  logic [2:0] port_rdy, port_err; logic conflict; logic [7:0] pipe_cpu_own;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  pipe_buf_ports uut (.*);

  // kind(2): 0 write, 1 read, 2 bind (data = pipe) | port(2) | data(8) | exp_ack(1) | exp_rd(8)
  localparam logic [20:0] VEC [16] = '{
    {2'd0, 2'd0, 8'hAA, 1'b1, 8'h00},
    {2'd0, 2'd0, 8'hBB, 1'b1, 8'h00},
    {2'd0, 2'd1, 8'h11, 1'b1, 8'h00},
    {2'd0, 2'd1, 8'h33, 1'b1, 8'h00},
    {2'd0, 2'd2, 8'h22, 1'b1, 8'h00},
    {2'd2, 2'd0, 8'h01, 1'b0, 8'h00},
    {2'd1, 2'd0, 8'h00, 1'b1, 8'hAA},
    {2'd1, 2'd0, 8'h00, 1'b1, 8'hBB},
    {2'd2, 2'd1, 8'h02, 1'b0, 8'h00},
    {2'd1, 2'd1, 8'h00, 1'b1, 8'h11},
    {2'd1, 2'd1, 8'h00, 1'b1, 8'h33},
    {2'd2, 2'd2, 8'h03, 1'b0, 8'h00},
    {2'd1, 2'd2, 8'h00, 1'b1, 8'h22},
    {2'd2, 2'd2, 8'h01, 1'b0, 8'h00},
    {2'd0, 2'd2, 8'h77, 1'b0, 8'h00},
    {2'd2, 2'd2, 8'h03, 1'b0, 8'h00}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bind_port(input logic [1:0] p, input logic [2:0] q);
    @(negedge clk); sel_we = 1; sel_port = p; sel_pipe = q;
    @(posedge clk); #1 sel_we = 0;
  endtask

  task automatic cfg(input logic [2:0] q, input logic [4:0] s, input logic [4:0] z);
    @(negedge clk); cfg_we = 1; cfg_pipe = q; cfg_start = s; cfg_size = z;
    @(posedge clk); #1 cfg_we = 0;
  endtask

  task automatic cpu_op(input logic [1:0] p, input logic wr, input logic [7:0] d,
                        input logic eack, input logic [7:0] erd, input bit crd, input string req);
    @(negedge clk); cpu_req = 1; cpu_port = p; cpu_wr = wr; cpu_wdata = d;
    #1 chk(cpu_ack === eack, req, cpu_ack, eack);
    @(posedge clk); #1 cpu_req = 0;
    if (crd && !wr && eack) chk(cpu_rdata === erd, req, cpu_rdata, erd);
  endtask

  task automatic sie_op(input logic [2:0] q, input logic wr, input logic [10:0] a,
                        input logic [7:0] d, input logic eack, input logic [7:0] erd, input string req);
    @(negedge clk); sie_req = 1; sie_pipe = q; sie_wr = wr; sie_addr = a; sie_wdata = d;
    #1 chk(sie_ack === eack, req, sie_ack, eack);
    @(posedge clk); #1 sie_req = 0;
    if (!wr && eack) chk(sie_rdata === erd, req, sie_rdata, erd);
  endtask

  initial begin
    #1_000_000;
    chk(1'b0, "watchdog R1..", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int acks;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(port_rdy === 3'b111, "R1 ready", port_rdy, 3'b111);
    chk(pipe_cpu_own === 8'hFF, "R1 R10 owner", pipe_cpu_own, 8'hFF);
    chk(conflict === 1'b0 && port_err === 3'b000, "R1 flags", {conflict, port_err}, 0);

    for (int q = 0; q < 8; q++)
      cfg(3'(q), 5'(4 * q), (q == 0) ? 5'd0 : (q == 1) ? 5'd1 : 5'd3);
    bind_port(2'd0, 3'd1);
    bind_port(2'd1, 3'd2);
    bind_port(2'd2, 3'd3);

    for (int i = 0; i < 16; i++) begin
      if (VEC[i][20:19] == 2'd2) bind_port(VEC[i][18:17], VEC[i][11:9]);
      else cpu_op(VEC[i][18:17], VEC[i][20:19] == 2'd0, VEC[i][16:9], VEC[i][8],
                  VEC[i][7:0], 1'b1, "R4 R6 table");
    end

    bind_port(2'd1, 3'd1);
    @(negedge clk);
    chk(conflict === 1'b1, "R6 conflict", conflict, 1);
    chk(port_rdy === 3'b101, "R6 grant", port_rdy, 3'b101);
    bind_port(2'd1, 3'd2);
    @(negedge clk);
    chk(conflict === 1'b0, "R6 clear", conflict, 0);

    bind_port(2'd0, 3'd0);
    acks = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk); cpu_req = 1; cpu_port = 0; cpu_wr = 1; cpu_wdata = 8'(i);
      #1 acks += int'(cpu_ack);
      @(posedge clk); #1 cpu_req = 0;
    end
    chk(acks == 64, "R2 size0 bytes", acks, 64);
    cpu_op(2'd0, 1'b1, 8'hEE, 1'b0, 8'h00, 1'b0, "R5 overflow");
    @(negedge clk);
    chk(port_err === 3'b001, "R5 err set", port_err, 3'b001);

    @(negedge clk); cpu_done = 1; cpu_done_port = 0;
    @(posedge clk); #1 cpu_done = 0;
    @(negedge clk);
    chk(pipe_cpu_own === 8'hFE, "R7 R10 handoff", pipe_cpu_own, 8'hFE);
    chk(port_rdy[0] === 1'b0, "R7 ready drop", port_rdy[0], 0);
    cpu_op(2'd0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, "R6 not ready");
    sie_op(3'd0, 1'b1, 11'd5, 8'h5A, 1'b1, 8'h00, "R9 sie write");
    sie_op(3'd0, 1'b1, 11'd63, 8'hC3, 1'b1, 8'h00, "R2 R9 last byte");
    sie_op(3'd0, 1'b1, 11'd64, 8'h99, 1'b0, 8'h00, "R2 R9 past end");
    sie_op(3'd0, 1'b0, 11'd5, 8'h00, 1'b1, 8'h5A, "R9 sie read");
    sie_op(3'd2, 1'b0, 11'd512, 8'h00, 1'b0, 8'h00, "R9 cpu owned");

    @(negedge clk); sie_done = 1; sie_done_pipe = 0;
    @(posedge clk); #1 sie_done = 0;
    @(negedge clk);
    chk(pipe_cpu_own === 8'hFF, "R8 return", pipe_cpu_own, 8'hFF);
    chk(port_err[0] === 1'b1, "R5 err sticky", port_err[0], 1);
    cpu_op(2'd0, 1'b0, 8'h00, 1'b1, 8'h00, 1'b1, "R8 rewind");
    for (int i = 1; i < 5; i++)
      cpu_op(2'd0, 1'b0, 8'h00, 1'b1, 8'(i), 1'b1, "R8 walk");
    cpu_op(2'd0, 1'b0, 8'h00, 1'b1, 8'h5A, 1'b1, "R8 R9 shared data");

    bind_port(2'd0, 3'd1);
    @(negedge clk);
    chk(port_err[0] === 1'b0, "R3 err clear", port_err[0], 0);
    cpu_op(2'd0, 1'b0, 8'h00, 1'b1, 8'hAA, 1'b1, "R3 base");
    @(negedge clk);
    sel_we = 1; sel_port = 0; sel_pipe = 3'd1;
    cpu_req = 1; cpu_port = 0; cpu_wr = 0;
    #1 chk(cpu_ack === 1'b0, "R3 same-cycle drop", cpu_ack, 0);
    @(posedge clk); #1 sel_we = 0; cpu_req = 0;
    cpu_op(2'd0, 1'b0, 8'h00, 1'b1, 8'hAA, 1'b1, "R3 rebind wins");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule